// File: doc/BRIEF.md
# Reset Line Controller with Status Readback

This block drives up to 128 peripheral reset lines from a small 32-bit register bus and reports, line by line, whether each downstream reset has taken effect. Software holds the requested level of every line in four request words. It changes one line with a read-modify-write of the word that holds it, then polls the matching status word until the line's bit reaches the expected value. Each request word and its status word can be accessed separately, so a 64-bit access made as two 32-bit accesses, low word first, behaves as two independent word accesses.

The status path is delayed and its polarity depends on the line. Each line's request passes through a two-stage synchroniser that advances only while that line's domain-clock-present input is high, so a line whose clock is gated keeps reporting its old state. For most lines a status bit of 0 means "held in reset". A parameter mask lists the lines whose status is not inverted. The status words read back exactly that mask when every line is held in reset, so software can test one rule for all lines: a line is in reset when its status bit equals its mask bit.

Top module: `rstline_ctrl`

## Requirements
- R1: A synchronous reset sets every request bit to 1, which drives every `line_rst` output high. After reset, each implemented request bit reads back as 1 and each status bit reads back as its mask bit.
- R2: A write to request word m (byte address 0x00 + 4*m) loads bit n into line 32*m+n. `line_rst` shows the new value after the clock edge that takes the write, and a read of that word returns it.
- R3: A write to one request word leaves the lines of every other request word unchanged.
- R4: Status bit l (status word l/32 at byte address 0x10 + 4*(l/32), bit l%32) equals mask bit l while the line's synchronised state is "in reset", and equals the inverse of mask bit l once the line is released.
- R5: The synchronised state advances one stage on each clock edge at which `dom_clk_en` for that line is high. After a request change with the enable held high, a status read presented in the second cycle after the write still returns the old value, and one presented in the third cycle returns the new value.
- R6: While `dom_clk_en` for a line is low, that line's status bit keeps its value whatever its request does. It catches up once the enable returns high.
- R7: The bus ignores writes to status addresses, to misaligned addresses (low two bits not zero), to request words above the implemented line count, and to byte addresses of 0x20 and above.
- R8: Reads of unmapped, misaligned or unimplemented addresses return 0. Request and status bits above `N_LINES` read as 0.
- R9: Read data is registered. `bus_rdata` reflects the address present at a clock edge and is valid after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and controller clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| dom_clk_en | input | N_LINES | Per-line flag, high while the line's domain clock runs |
| line_rst | output | N_LINES | Registered reset outputs, high = held in reset |

## Verification
The checks assume that reads never have side effects and that `dom_clk_en` is a level that stays steady between clock edges. The bench changes inputs only on falling edges and never pulses `bus_we` for more than one cycle per access. It waits at least three cycles after each request change before it reads a settled status, except in the latency and gated-clock checks, where it reads at the exact cycles named in R5 and R6. Every line of a 40-line build is released and re-asserted in turn, and each whole request vector and status word is compared with values the bench derives from its own copy of the request words and of the mask.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
  localparam int WORD_W  = 32;
  localparam int MAX_WORDS = 4;
  localparam int IDX_W   = 2;

  function automatic int words_for(input int n);
    return (n + WORD_W - 1) / WORD_W;
  endfunction

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_REQ    = 2'd1,
    ACC_STATUS = 2'd2
  } acc_e;
endpackage

// File: rtl/rlc_regfile.sv
module rlc_regfile
  import rlc_pkg::*;
#(
  parameter int N_LINES = 128,
  parameter int ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [WORD_W-1:0]  bus_wdata,
  output acc_e               acc_kind,
  output logic [IDX_W-1:0]   acc_idx,
  output logic [N_LINES-1:0] req_q
);
  localparam int NW = words_for(N_LINES);

  logic aligned, in_window, in_range, wr_req;

  always_comb begin
    aligned   = (bus_addr[1:0] == 2'b00);
    in_window = (bus_addr[ADDR_W-1:5] == '0);
    acc_idx   = bus_addr[3:2];
    in_range  = (int'(acc_idx) < NW);
    if (!aligned || !in_window || !in_range) acc_kind = ACC_NONE;
    else if (bus_addr[4])                    acc_kind = ACC_STATUS;
    else                                     acc_kind = ACC_REQ;
  end

  assign wr_req = bus_we && (acc_kind == ACC_REQ);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    localparam int W = i / WORD_W;
    localparam int B = i % WORD_W;

    always_ff @(posedge clk) begin
      if (rst)                                req_q[i] <= 1'b1;
      else if (wr_req && acc_idx == IDX_W'(W)) req_q[i] <= bus_wdata[B];
    end

    // R2
    line_load_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_req && acc_idx == IDX_W'(W)) |=> (req_q[i] == $past(bus_wdata[B])));

    // R3
    other_word_chk: assert property (@(posedge clk) disable iff (rst)
      (bus_we && acc_idx != IDX_W'(W)) |=> $stable(req_q[i]));
  end

  // R1
  all_held_chk: assert property (@(posedge clk) rst |=> (&req_q));

  // R7
  ignored_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_we && acc_kind != ACC_REQ) |=> $stable(req_q));
endmodule

// File: rtl/rlc_line_sync.sv
module rlc_line_sync #(
  parameter int N_LINES = 128
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_LINES-1:0] line_req,
  input  logic [N_LINES-1:0] dom_en,
  output logic [N_LINES-1:0] seen_q
);
  logic [N_LINES-1:0] meta_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_sync
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q[i] <= 1'b1;
        seen_q[i] <= 1'b1;
      end else if (dom_en[i]) begin
        meta_q[i] <= line_req[i];
        seen_q[i] <= meta_q[i];
      end
    end

    // R6
    gated_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !dom_en[i] |=> $stable(seen_q[i]));

    // R5
    stage_adv_chk: assert property (@(posedge clk) disable iff (rst)
      dom_en[i] |=> (seen_q[i] == $past(meta_q[i])));
  end
endmodule

// File: rtl/rlc_readback.sv
module rlc_readback
  import rlc_pkg::*;
#(
  parameter int N_LINES = 128,
  parameter logic [N_LINES-1:0] STAT_WHEN_HELD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  acc_e               acc_kind,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic [N_LINES-1:0] req_q,
  input  logic [N_LINES-1:0] seen_q,
  output logic [WORD_W-1:0]  rdata_q
);
  localparam int NW  = words_for(N_LINES);
  localparam int PAD = NW * WORD_W;

  logic [PAD-1:0]    req_pad, stat_pad;
  logic [WORD_W-1:0] rdata_d;

  always_comb begin
    req_pad  = '0;
    stat_pad = '0;
    req_pad[N_LINES-1:0]  = req_q;
    stat_pad[N_LINES-1:0] = STAT_WHEN_HELD ^ ~seen_q;
  end

  always_comb begin
    rdata_d = '0;
    for (int w = 0; w < NW; w++) begin
      if (acc_idx == IDX_W'(w)) begin
        if (acc_kind == ACC_REQ)    rdata_d = req_pad[w*WORD_W +: WORD_W];
        if (acc_kind == ACC_STATUS) rdata_d = stat_pad[w*WORD_W +: WORD_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else     rdata_q <= rdata_d;
  end

  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_NONE) |=> (rdata_q == '0));

  // R4
  for (genvar i = 0; i < N_LINES; i++) begin : g_pol
    status_pol_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_kind == ACC_STATUS && acc_idx == IDX_W'(i / WORD_W)) |=>
        (rdata_q[i % WORD_W] == ($past(seen_q[i]) ? STAT_WHEN_HELD[i] : !STAT_WHEN_HELD[i])));
  end
endmodule

// File: rtl/rstline_ctrl.sv
module rstline_ctrl
  import rlc_pkg::*;
#(
  parameter int N_LINES = 128,
  parameter int ADDR_W  = 8,
  parameter logic [N_LINES-1:0] STAT_WHEN_HELD = N_LINES'(7)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [N_LINES-1:0] dom_clk_en,
  output logic [N_LINES-1:0] line_rst
);
  acc_e               acc_kind;
  logic [IDX_W-1:0]   acc_idx;
  logic [N_LINES-1:0] req_q, seen_q;

  rlc_regfile #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .acc_kind(acc_kind), .acc_idx(acc_idx), .req_q(req_q)
  );

  rlc_line_sync #(.N_LINES(N_LINES)) u_sync (
    .clk(clk), .rst(rst), .line_req(req_q), .dom_en(dom_clk_en), .seen_q(seen_q)
  );

  rlc_readback #(.N_LINES(N_LINES), .STAT_WHEN_HELD(STAT_WHEN_HELD)) u_rd (
    .clk(clk), .rst(rst), .acc_kind(acc_kind), .acc_idx(acc_idx),
    .req_q(req_q), .seen_q(seen_q), .rdata_q(bus_rdata)
  );

  assign line_rst = req_q;

  // R9
  rd_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_kind == ACC_REQ && acc_idx == '0) |=> (bus_rdata[0] == $past(req_q[0])));
endmodule

// File: tb/sim_rstline_ctrl.sv
`timescale 1ns/1ps
module sim_rstline_ctrl;
  localparam int N  = 40;
  localparam int AW = 8;
  localparam logic [N-1:0] MASK = (40'd1 << 0) | (40'd1 << 7) | (40'd1 << 33);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  dom_clk_en = '1;
  logic [N-1:0]  line_rst;

  int vecs = 0;
  int errs = 0;
  logic [N-1:0] sh;    // bench copy of requests
  logic [N-1:0] seen;  // state the status path should report
  logic [31:0]  rd;

  always #4 clk = ~clk;

  rstline_ctrl #(.N_LINES(N), .ADDR_W(AW), .STAT_WHEN_HELD(MASK)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dom_clk_en(dom_clk_en), .line_rst(line_rst)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    vecs++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rdw(input logic [AW-1:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic [31:0] req_word(input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++) if (w*32+b < N) r[b] = sh[w*32+b];
    return r;
  endfunction

  function automatic logic [31:0] stat_word(input int w);
    logic [31:0] r = '0;
    for (int b = 0; b < 32; b++)
      if (w*32+b < N) r[b] = seen[w*32+b] ? MASK[w*32+b] : !MASK[w*32+b];
    return r;
  endfunction

  task automatic set_line(input int l, input logic v);
    int w = l / 32;
    sh[l] = v;
    wr(AW'(w*4), req_word(w));
    chk("R2/R3 line_rst vector", 64'(line_rst), 64'(sh));
    idle(3);
    seen = sh;
    rdw(AW'(8'h10 + w*4), rd);
    chk("R4 status word", 64'(rd), 64'(stat_word(w)));
    rdw(AW'(w*4), rd);
    chk("R2 request readback", 64'(rd), 64'(req_word(w)));
  endtask

  initial begin
    #(8ns * 200000);
    errs++;
    $display("FAIL watchdog expired got=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    sh = '1; seen = '1;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 line_rst after reset", 64'(line_rst), 64'(sh));
    rdw(8'h00, rd); chk("R1 request word0", 64'(rd), 64'hffff_ffff);
    rdw(8'h04, rd); chk("R1/R8 request word1 upper bits zero", 64'(rd), 64'h0000_00ff);
    rdw(8'h10, rd); chk("R1/R4 status word0 equals mask", 64'(rd), 64'h0000_0081);
    rdw(8'h14, rd); chk("R1/R4 status word1 equals mask", 64'(rd), 64'h0000_0002);

    // R8 unmapped reads
    rdw(8'h08, rd); chk("R8 unimplemented request word", 64'(rd), 64'h0);
    rdw(8'h1C, rd); chk("R8 unimplemented status word", 64'(rd), 64'h0);
    rdw(8'h24, rd); chk("R8 address above window", 64'(rd), 64'h0);
    rdw(8'h01, rd); chk("R8 misaligned read", 64'(rd), 64'h0);

    // R2 R3 R4 sweep: release then re-hold every line
    for (int l = 0; l < N; l++) begin
      set_line(l, 1'b0);
      set_line(l, 1'b1);
    end
    // release all in word1, hold word0, check word independence
    sh[39:32] = '0;
    wr(8'h04, req_word(1));
    chk("R3 word0 lines untouched", 64'(line_rst[31:0]), 64'hffff_ffff);
    idle(3); seen = sh;
    rdw(8'h14, rd); chk("R4 word1 all released", 64'(rd), 64'(stat_word(1)));

    // R5 latency on line 12
    sh[12] = 1'b0;
    wr(8'h00, req_word(0));
    rdw(8'h10, rd); // sampled after write edge + 1
    rdw(8'h10, rd); // after write edge + 2
    chk("R5 status old in second cycle", 64'(rd[12]), 64'(MASK[12]));
    rdw(8'h10, rd); // after write edge + 3
    chk("R5 status new in third cycle", 64'(rd[12]), 64'(!MASK[12]));
    seen = sh;

    // R6 gated domain clock on line 5
    dom_clk_en[5] = 1'b0;
    sh[5] = 1'b0;
    wr(8'h00, req_word(0));
    chk("R6 line_rst follows request while gated", 64'(line_rst[5]), 64'h0);
    idle(6);
    rdw(8'h10, rd); chk("R6 status stale while gated", 64'(rd), 64'(stat_word(0)));
    dom_clk_en[5] = 1'b1;
    idle(3); seen = sh;
    rdw(8'h10, rd); chk("R6 status catches up", 64'(rd), 64'(stat_word(0)));

    // R7 ignored writes
    wr(8'h10, 32'h0);
    wr(8'h14, 32'hffff_ffff);
    wr(8'h08, 32'h0);
    wr(8'h28, 32'h0);
    wr(8'h02, 32'h0);
    wr(8'h44, 32'h0);
    chk("R7 line_rst after ignored writes", 64'(line_rst), 64'(sh));
    rdw(8'h00, rd); chk("R7 request word0 unchanged", 64'(rd), 64'(req_word(0)));
    rdw(8'h04, rd); chk("R7 request word1 unchanged", 64'(rd), 64'(req_word(1)));

    // R9 registered read: address change visible only after an edge
    bus_addr = 8'h00;
    @(negedge clk);
    bus_addr = 8'h24;
    #1;
    chk("R9 rdata holds until edge", 64'(bus_rdata), 64'(req_word(0)));
    @(negedge clk);
    chk("R9 rdata updates after edge", 64'(bus_rdata), 64'h0);

    // R1 reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    sh = '1; seen = '1;
    chk("R1 line_rst after second reset", 64'(line_rst), 64'(sh));
    rdw(8'h10, rd); chk("R1 status word0 after reset", 64'(rd), 64'(stat_word(0)));

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule